// File: doc/BRIEF.md
# Bitstream header clock-ratio selector

This block sits beside a configuration-image data path and watches the leading words of each image as they stream past. It counts accepted 32-bit words from a start-of-image strobe. It reads one flag from a fixed early header word: the image counts as encrypted. It reads a second flag from a later fixed header word: the image counts as compressed. When the later word arrives, the block combines both flags with the selected configuration bus width and emits a 2-bit clock-to-data ratio code. A one-cycle strobe marks the code as ready. Decryption and decompression themselves are not part of the block.

If the image ends before the later header word has been accepted, no ratio is produced. A sticky error flag is raised instead. Once the ratio has been produced, the block ignores the rest of the image until the next start strobe.

The controller has four states. `ST_IDLE` is the state after reset. `ST_COLLECT` counts header words. `ST_DONE` means a ratio was produced. `ST_FAULT` means the image ended early. The transitions are as follows. A start strobe moves any state, including `ST_COLLECT` itself, into `ST_COLLECT`. In `ST_COLLECT`, accepting the compression word moves to `ST_DONE`. In `ST_COLLECT`, accepting a word marked last before that moves to `ST_FAULT`. In every other case the state holds.

Top module: `hdr_ratio_sel`

## Requirements
- R1: After reset `ratio_o` is 0, and `ratio_valid_o` and `short_err_o` are low.
- R2: The image is encrypted when word 69 (zero-based, counting accepted words after the start strobe) has bits [3:2] nonzero. Both patterns 01 and 10 count as encrypted.
- R3: The image is compressed when word 229 has bit 1 equal to 0.
- R4: Ratio codes are 0 = x1, 1 = x2, 2 = x4 and 3 = x8. An image that is neither encrypted nor compressed gives code 0 at either width.
- R5: With `wide_i` = 0 (16-bit), a compressed image gives code 2, whether or not it is encrypted. An encrypted-only image gives code 1.
- R6: With `wide_i` = 1 (32-bit), a compressed image gives code 3, whether or not it is encrypted. An encrypted-only image gives code 2. `wide_i` is sampled in the cycle word 229 is accepted.
- R7: `ratio_valid_o` is high for exactly the one cycle after word 229 is accepted. At that same edge `ratio_o` takes the code, and it then holds until the next start strobe.
- R8: After word 229, further words, including one marked last, change no output until the next start strobe.
- R9: If a word marked last (`last_i` = 1 with `word_valid_i` = 1) is accepted as word 0..228, then `short_err_o` rises on the next cycle and stays high until the next start strobe. No ratio strobe is produced for that image. A last mark on word 229 itself gives a ratio and no error.
- R10: A start strobe clears `ratio_o` and `short_err_o` on the next cycle and restarts counting from word 0, even in the middle of an image. A word presented in the start cycle is not counted. Words seen before the first start are ignored.
- R11: Cycles with `word_valid_i` low are not counted as words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start-of-image strobe |
| word_valid_i | input | 1 | Word qualifier |
| word_i | input | 32 | Image word |
| last_i | input | 1 | Marks the final word of the image (with valid) |
| wide_i | input | 1 | Bus width select: 0 = 16-bit, 1 = 32-bit |
| ratio_o | output | 2 | Clock-to-data ratio code |
| ratio_valid_o | output | 1 | One-cycle strobe: ratio code ready |
| short_err_o | output | 1 | Sticky error: image ended before the header was complete |

## Verification
The bench builds the block with its default parameters: header words 69 and 229, and masks on bits [3:2] and bit 1. Every image therefore runs the real header length, which costs only a few hundred cycles. With these values the bench can reach the exact boundary images: one ending on word 228, one ending on word 229, and one restarted part-way through. All eight flag and width combinations, gapped valid patterns, and both encrypted bit patterns are run against a behavioural model compared every cycle.

// File: rtl/hdr_ratio_pkg.sv
package hdr_ratio_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_DONE    = 2'd2,
        ST_FAULT   = 2'd3
    } hdr_state_e;

    localparam logic [1:0] RATIO_X1 = 2'd0;
    localparam logic [1:0] RATIO_X2 = 2'd1;
    localparam logic [1:0] RATIO_X4 = 2'd2;
    localparam logic [1:0] RATIO_X8 = 2'd3;

endpackage

// File: rtl/hdr_word_ctr.sv
module hdr_word_ctr #(
    parameter int ENC_WORD = 69,
    parameter int CMP_WORD = 229
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_enc,
    output logic at_cmp
);
    localparam int CNT_W = $clog2(CMP_WORD + 2);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign at_enc = (cnt_q == CNT_W'(ENC_WORD));
    assign at_cmp = (cnt_q == CNT_W'(CMP_WORD));
endmodule

// File: rtl/hdr_flag_cap.sv
module hdr_flag_cap #(
    parameter int          WORD_W   = 32,
    parameter logic [31:0] ENC_MASK = 32'h0000_000C,
    parameter logic [31:0] CMP_MASK = 32'h0000_0002
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              cap_enc,
    input  logic [WORD_W-1:0] word,
    output logic              enc_q,
    output logic              cmp_now
);
    localparam logic [WORD_W-1:0] ENC_M = ENC_MASK[WORD_W-1:0];
    localparam logic [WORD_W-1:0] CMP_M = CMP_MASK[WORD_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            enc_q <= 1'b0;
        end else if (cap_enc) begin
            enc_q <= |(word & ENC_M);
        end
    end

    // compressed when the marker bit is clear
    assign cmp_now = ((word & CMP_M) == '0);
endmodule

// File: rtl/hdr_ratio_enc.sv
module hdr_ratio_enc
    import hdr_ratio_pkg::*;
(
    input  logic       enc,
    input  logic       cmp,
    input  logic       wide,
    output logic [1:0] code
);
    always_comb begin
        if (!enc && !cmp) begin
            code = RATIO_X1;
        end else begin
            code = cmp ? RATIO_X4 : RATIO_X2;
            if (wide) begin
                code = code + 2'd1;
            end
        end
    end
endmodule

// File: rtl/hdr_ratio_sel.sv
module hdr_ratio_sel
    import hdr_ratio_pkg::*;
#(
    parameter int          WORD_W   = 32,
    parameter int          ENC_WORD = 69,
    parameter int          CMP_WORD = 229,
    parameter logic [31:0] ENC_MASK = 32'h0000_000C,
    parameter logic [31:0] CMP_MASK = 32'h0000_0002
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              word_valid_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              last_i,
    input  logic              wide_i,
    output logic [1:0]        ratio_o,
    output logic              ratio_valid_o,
    output logic              short_err_o
);
    hdr_state_e state_q, state_d;

    logic accept;
    logic at_enc, at_cmp;
    logic enc_q, cmp_now;
    logic [1:0] code;
    logic hdr_complete, hdr_short;

    assign accept       = (state_q == ST_COLLECT) && word_valid_i && !start_i;
    assign hdr_complete = accept && at_cmp;
    assign hdr_short    = accept && !at_cmp && last_i;

    hdr_word_ctr #(
        .ENC_WORD (ENC_WORD),
        .CMP_WORD (CMP_WORD)
    ) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (start_i),
        .inc    (accept),
        .at_enc (at_enc),
        .at_cmp (at_cmp)
    );

    hdr_flag_cap #(
        .WORD_W   (WORD_W),
        .ENC_MASK (ENC_MASK),
        .CMP_MASK (CMP_MASK)
    ) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (start_i),
        .cap_enc (accept && at_enc),
        .word    (word_i),
        .enc_q   (enc_q),
        .cmp_now (cmp_now)
    );

    hdr_ratio_enc u_enc (
        .enc  (enc_q),
        .cmp  (cmp_now),
        .wide (wide_i),
        .code (code)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) state_d = ST_COLLECT;
            end
            ST_COLLECT: begin
                if (start_i)           state_d = ST_COLLECT;
                else if (hdr_complete) state_d = ST_DONE;
                else if (hdr_short)    state_d = ST_FAULT;
            end
            ST_DONE: begin
                if (start_i) state_d = ST_COLLECT;
            end
            ST_FAULT: begin
                if (start_i) state_d = ST_COLLECT;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ratio_o       <= RATIO_X1;
            ratio_valid_o <= 1'b0;
            short_err_o   <= 1'b0;
        end else begin
            ratio_valid_o <= 1'b0;
            if (start_i) begin
                ratio_o     <= RATIO_X1;
                short_err_o <= 1'b0;
            end else if (hdr_complete) begin
                ratio_o       <= code;
                ratio_valid_o <= 1'b1;
            end else if (hdr_short) begin
                short_err_o <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/hdr_ratio_sel_chk.sv
module hdr_ratio_sel_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       wide_i,
    input logic [1:0] ratio_o,
    input logic       ratio_valid_o,
    input logic       short_err_o
);
    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ratio_valid_o |=> !ratio_valid_o); // R7

    AST_RATIO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(start_i) && !ratio_valid_o) |-> $stable(ratio_o)); // R7

    AST_NARROW_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio_valid_o && !$past(wide_i)) |-> (ratio_o != 2'd3)); // R5

    AST_WIDE_NO_X2: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio_valid_o && $past(wide_i)) |-> (ratio_o != 2'd1)); // R6

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (short_err_o && !start_i) |=> short_err_o); // R9

    AST_ERR_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(short_err_o && ratio_valid_o)); // R9

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (!short_err_o && !ratio_valid_o && ratio_o == 2'd0)); // R10
endmodule

bind hdr_ratio_sel hdr_ratio_sel_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .wide_i        (wide_i),
    .ratio_o       (ratio_o),
    .ratio_valid_o (ratio_valid_o),
    .short_err_o   (short_err_o)
);

// File: tb/tb_hdr_ratio_sel.sv
`timescale 1ns/1ps
module tb_hdr_ratio_sel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        word_valid_i = 1'b0;
    logic [31:0] word_i = '0;
    logic        last_i = 1'b0;
    logic        wide_i = 1'b0;
    logic [1:0]  ratio_o;
    logic        ratio_valid_o;
    logic        short_err_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string cur_req = "R1";

    // behavioural reference state
    int   m_idx = 0;
    bit   m_active = 0;
    bit   m_enc = 0;
    logic [1:0] m_ratio = 0;
    bit   m_valid = 0;
    bit   m_err = 0;

    always #2.5 clk = ~clk;

    hdr_ratio_sel dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .word_valid_i  (word_valid_i),
        .word_i        (word_i),
        .last_i        (last_i),
        .wide_i        (wide_i),
        .ratio_o       (ratio_o),
        .ratio_valid_o (ratio_valid_o),
        .short_err_o   (short_err_o)
    );

    function automatic logic [1:0] ref_code(bit enc, bit cmp, bit wide);
        if (!enc && !cmp) return 2'd0;
        if (!wide)        return cmp ? 2'd2 : 2'd1;
        return cmp ? 2'd3 : 2'd2;
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_idx = 0; m_active = 0; m_enc = 0;
            m_ratio = 0; m_valid = 0; m_err = 0;
        end else begin
            m_valid = 0;
            if (start_i) begin
                m_idx = 0; m_active = 1; m_enc = 0; m_ratio = 0; m_err = 0;
            end else if (m_active && word_valid_i) begin
                if (m_idx == 69) m_enc = (word_i[3:2] != 2'b00);
                if (m_idx == 229) begin
                    m_ratio  = ref_code(m_enc, !word_i[1], wide_i);
                    m_valid  = 1;
                    m_active = 0;
                end else if (last_i) begin
                    m_err    = 1;
                    m_active = 0;
                end
                m_idx++;
            end
        end
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: run hung (actual %0d cycles, expected < 150000)", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic cmp_outputs();
        checks++;
        if (ratio_o !== m_ratio || ratio_valid_o !== m_valid || short_err_o !== m_err) begin
            errors++;
            $display("FAIL %s: actual ratio=%0d valid=%0b err=%0b expected ratio=%0d valid=%0b err=%0b",
                     cur_req, ratio_o, ratio_valid_o, short_err_o, m_ratio, m_valid, m_err);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) cmp_outputs();
    end

    task automatic expect_now(string req, logic [1:0] r, bit v, bit e);
        checks++;
        if (ratio_o !== r || ratio_valid_o !== v || short_err_o !== e) begin
            errors++;
            $display("FAIL %s: actual ratio=%0d valid=%0b err=%0b expected ratio=%0d valid=%0b err=%0b",
                     req, ratio_o, ratio_valid_o, short_err_o, r, v, e);
        end
    endtask

    // sends a start strobe then n words; last on the final word if mark_last
    task automatic send_image(int n, logic [1:0] encb, bit cb1, bit w,
                              bit mark_last, bit gaps);
        @(negedge clk);
        start_i = 1; wide_i = w; word_valid_i = 1; word_i = 32'hFFFF_FFFF;
        @(negedge clk);
        start_i = 0;
        for (int i = 0; i < n; i++) begin
            if (gaps && ($urandom_range(0, 3) == 0)) begin
                word_valid_i = 0; word_i = $urandom; last_i = 1;
                @(negedge clk);
            end
            word_valid_i = 1;
            word_i = $urandom;
            if (i == 69)  word_i[3:2] = encb;
            if (i == 229) word_i[1]   = cb1;
            last_i = mark_last && (i == n - 1);
            @(negedge clk);
        end
        word_valid_i = 0; last_i = 0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        cur_req = "R1";
        expect_now("R1", 2'd0, 0, 0);
        rst_n = 1;
        @(negedge clk);
        expect_now("R1", 2'd0, 0, 0);

        // words before any start are ignored
        cur_req = "R10";
        word_valid_i = 1; last_i = 1; word_i = 32'h0;
        repeat (4) @(negedge clk);
        word_valid_i = 0; last_i = 0;
        @(negedge clk);
        expect_now("R10", 2'd0, 0, 0);

        cur_req = "R4";  send_image(240, 2'b00, 1'b1, 1'b0, 1, 0);
        expect_now("R4", 2'd0, 0, 0);
        cur_req = "R4";  send_image(240, 2'b00, 1'b1, 1'b1, 1, 0);
        cur_req = "R5";  send_image(230, 2'b00, 1'b0, 1'b0, 1, 0);
        expect_now("R5", 2'd2, 0, 0);
        cur_req = "R5";  send_image(230, 2'b01, 1'b1, 1'b0, 0, 0);
        expect_now("R5", 2'd1, 0, 0);
        cur_req = "R5";  send_image(235, 2'b11, 1'b0, 1'b0, 1, 1);
        cur_req = "R6";  send_image(230, 2'b00, 1'b0, 1'b1, 0, 0);
        expect_now("R6", 2'd3, 0, 0);
        cur_req = "R6";  send_image(230, 2'b10, 1'b1, 1'b1, 0, 1);
        expect_now("R6", 2'd2, 0, 0);
        cur_req = "R6";  send_image(230, 2'b01, 1'b0, 1'b1, 0, 0);
        cur_req = "R2";  send_image(230, 2'b10, 1'b1, 1'b0, 0, 0);
        expect_now("R2", 2'd1, 0, 0);
        cur_req = "R3";  send_image(230, 2'b00, 1'b1, 1'b1, 0, 0);
        expect_now("R3", 2'd0, 0, 0);

        // trailing words after the header, last mark included
        cur_req = "R8";  send_image(300, 2'b01, 1'b0, 1'b1, 1, 1);
        expect_now("R8", 2'd3, 0, 0);

        // early ends
        cur_req = "R9";  send_image(100, 2'b01, 1'b0, 1'b0, 1, 0);
        expect_now("R9", 2'd0, 0, 1);
        repeat (5) @(negedge clk);
        expect_now("R9", 2'd0, 0, 1);
        cur_req = "R9";  send_image(229, 2'b01, 1'b0, 1'b1, 1, 1);
        expect_now("R9", 2'd0, 0, 1);
        cur_req = "R9";  send_image(230, 2'b01, 1'b0, 1'b1, 1, 0);
        expect_now("R9", 2'd3, 0, 0);

        // gaps in valid
        cur_req = "R11"; send_image(230, 2'b11, 1'b1, 1'b0, 1, 1);
        expect_now("R11", 2'd1, 0, 0);

        // restart in the middle of an image
        cur_req = "R10";
        @(negedge clk);
        start_i = 1; wide_i = 1; word_valid_i = 0;
        @(negedge clk);
        start_i = 0;
        for (int i = 0; i < 150; i++) begin
            word_valid_i = 1; word_i = 32'h0; last_i = 0;
            @(negedge clk);
        end
        send_image(230, 2'b00, 1'b0, 1'b0, 1, 0);
        expect_now("R10", 2'd2, 0, 0);

        // start clears a pending error
        cur_req = "R10";
        send_image(10, 2'b00, 1'b0, 1'b0, 1, 0);
        expect_now("R9", 2'd0, 0, 1);
        @(negedge clk);
        start_i = 1;
        @(negedge clk);
        start_i = 0;
        expect_now("R10", 2'd0, 0, 0);
        repeat (3) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule